// File: doc/BRIEF.md
# IDE Channel Interrupt Latch Register

This block is an 8-bit mode and status register for a two-channel disk controller. Each channel has a raw interrupt line. When that line rises, the channel's pending flag in the register is set and stays set until software removes it. Software reads the whole byte through a simple byte read port and writes it through a byte write port.

Pending flags are write-one-to-clear. A write with a zero in a flag position leaves that flag alone. Software can therefore acknowledge one channel without disturbing the other, even though both flags share one byte. The same byte also holds:

- two write-only control bits, which always read back as zero but are driven out as control levels;
- two mode bits, readable and writable, also driven out;
- two plain storage bits.

For each channel, the block also produces a qualified interrupt. It is the channel's pending flag ANDed with bit 2 of that channel's DMA status byte.

Top module: `ide_irq_latch`

## Requirements
- R1: A synchronous reset, active high, clears every register bit. After reset, `rd_data` reads 0x00, `ctrl_out` and `mode_out` are zero, and both qualified interrupts are low.
- R2: A low-to-high transition of `chan_irq[0]` sets bit 2 (primary pending). A low-to-high transition of `chan_irq[1]` sets bit 3 (secondary pending). The bit is visible on `rd_data` after the clock edge that samples the high level.
- R3: A pending bit is set by an edge, not by a level. If a channel's interrupt input stays high after its bit has been cleared, the bit stays clear.
- R4: Writing 1 to bit 2 clears the primary pending bit, and writing 1 to bit 3 clears the secondary pending bit. Writing 0 to either position leaves that bit unchanged, so a write of 0x04 clears only the primary flag.
- R5: If a rising edge and a write-one-to-clear on the same channel occur in the same clock, the pending bit ends up set.
- R6: Bits 1:0 are write-only. They always read as zero on `rd_data`, and the last value written to them appears on `ctrl_out`.
- R7: Bits 5:4 are mode bits. Each write loads them, they read back on `rd_data[5:4]` and appear on `mode_out`, and changing them leaves the pending bits unchanged. Clearing pending bits leaves them unchanged.
- R8: Bits 7:6 are plain storage. Each write loads them, and they read back unchanged.
- R9: `qual_irq[n]` is high exactly when channel n's pending bit is set and bit 2 of `dma_stat0` (n=0) or `dma_stat1` (n=1) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte written to the register |
| rd_data | output | 8 | Current register read value |
| chan_irq | input | 2 | Raw interrupt lines, bit 0 primary, bit 1 secondary |
| dma_stat0 | input | 8 | Primary channel DMA status byte |
| dma_stat1 | input | 8 | Secondary channel DMA status byte |
| ctrl_out | output | 2 | Last value written to the write-only bits 1:0 |
| mode_out | output | 2 | Mode bits 5:4 |
| qual_irq | output | 2 | Qualified interrupt per channel |

## Verification
The read path and the qualified interrupts are combinational from the stored bits. A wrong pending, mode or storage bit therefore shows on `rd_data` or `qual_irq` in the same cycle it is stored, one clock after the write or edge that caused it. A wrong edge-detect history is different: it stays hidden until the next transition of the interrupt line. It then appears either as a flag set with no edge, or as a missed set, one clock after that transition. For this reason the bench holds lines high across clears and re-raises them at the same moment as a clear.

// File: rtl/ide_irq_latch.sv
module ide_irq_latch #(
  parameter int NCH      = 2,
  parameter int STAT_BIT = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [1:0] chan_irq,
  input  logic [7:0] dma_stat0,
  input  logic [7:0] dma_stat1,
  output logic [1:0] ctrl_out,
  output logic [1:0] mode_out,
  output logic [1:0] qual_irq
);
  localparam int PEND_LO = 2;

  logic [NCH-1:0] irq_prev;
  logic [NCH-1:0] pend;
  logic [NCH-1:0] rise;
  logic [NCH-1:0] clr;
  logic [NCH-1:0] stat_irq;
  logic [1:0]     ctrl_q;
  logic [1:0]     mode_q;
  logic [1:0]     keep_q;

  assign rise     = chan_irq & ~irq_prev;
  assign clr      = wr_en ? wr_data[PEND_LO +: NCH] : '0;
  assign stat_irq = {dma_stat1[STAT_BIT], dma_stat0[STAT_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_prev <= '0;
      pend     <= '0;
    end else begin
      irq_prev <= chan_irq;
      pend     <= rise | (pend & ~clr);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
      keep_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wr_data[1:0];
      mode_q <= wr_data[5:4];
      keep_q <= wr_data[7:6];
    end
  end

  assign rd_data  = {keep_q, mode_q, pend, 2'b00};
  assign ctrl_out = ctrl_q;
  assign mode_out = mode_q;
  assign qual_irq = pend & stat_irq;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (rd_data == 8'h00 && qual_irq == 2'b00));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(mode_out));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R2
    edge_set_chk: assert property (@(posedge clk) disable iff (rst)
      (chan_irq[i] && !irq_prev[i]) |=> rd_data[PEND_LO+i]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (chan_irq[i] && !irq_prev[i] && wr_en && wr_data[PEND_LO+i]) |=> rd_data[PEND_LO+i]);
    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
      (!rd_data[PEND_LO+i] && !(chan_irq[i] && !irq_prev[i])) |=> !rd_data[PEND_LO+i]);
    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[PEND_LO+i] && !(chan_irq[i] && !irq_prev[i])) |=> !rd_data[PEND_LO+i]);
    // R9
    qual_chk: assert property (@(posedge clk) disable iff (rst)
      qual_irq[i] |-> rd_data[PEND_LO+i]);
  end
endmodule

// File: tb/ide_irq_latch_tb.sv
module ide_irq_latch_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] chan_irq;
  logic [7:0] dma_stat0;
  logic [7:0] dma_stat1;
  logic [1:0] ctrl_out;
  logic [1:0] mode_out;
  logic [1:0] qual_irq;

  int vectors = 0;
  int errors  = 0;

  always #2.5 clk = ~clk;

  ide_irq_latch u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .chan_irq(chan_irq), .dma_stat0(dma_stat0), .dma_stat1(dma_stat1),
    .ctrl_out(ctrl_out), .mode_out(mode_out), .qual_irq(qual_irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; wr_data = 8'h00; chan_irq = 2'b00;
    dma_stat0 = 8'h00; dma_stat1 = 8'h00;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    wr(8'hF3);
    chan_irq = 2'b11; step(); chan_irq = 2'b00;
    dma_stat0 = 8'h04; dma_stat1 = 8'h04;
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 ctrl/mode", {4'h0, ctrl_out, mode_out}, 8'h00);
    chk("R1 qual", {6'h0, qual_irq}, 8'h00);
    dma_stat0 = 8'h00; dma_stat1 = 8'h00;
  endtask

  task automatic t_edge_set();
    do_reset();
    chan_irq = 2'b01; step();
    chk("R2 primary set", rd_data, 8'h04);
    chan_irq = 2'b11; step();
    chk("R2 secondary set", rd_data, 8'h0C);
    chan_irq = 2'b00; step();
    chk("R2 flags stay after line drops", rd_data, 8'h0C);
  endtask

  task automatic t_w1c();
    do_reset();
    chan_irq = 2'b11; step(); chan_irq = 2'b00; step();
    wr(8'h00);
    chk("R4 zero write keeps flags", rd_data, 8'h0C);
    wr(8'h04);
    chk("R4 clear primary only", rd_data, 8'h08);
    wr(8'h08);
    chk("R4 clear secondary", rd_data, 8'h00);
  endtask

  task automatic t_level();
    do_reset();
    chan_irq = 2'b01; step();
    wr(8'h04);
    chk("R3 held line after clear", rd_data, 8'h00);
    step();
    chk("R3 still clear", rd_data, 8'h00);
  endtask

  task automatic t_set_wins();
    do_reset();
    chan_irq = 2'b10; step(); chan_irq = 2'b00; step();
    chk("R5 setup", rd_data, 8'h08);
    chan_irq = 2'b10; wr_en = 1'b1; wr_data = 8'h08;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
    chk("R5 set beats clear", rd_data, 8'h08);
  endtask

  task automatic t_fields();
    do_reset();
    wr(8'h03);
    chk("R6 write-only reads zero", rd_data, 8'h00);
    chk("R6 ctrl_out", {6'h0, ctrl_out}, 8'h03);
    chan_irq = 2'b11; step(); chan_irq = 2'b00;
    wr(8'h30);
    chk("R7 mode write keeps flags", rd_data, 8'h3C);
    chk("R7 mode_out", {6'h0, mode_out}, 8'h03);
    wr(8'h3C);
    chk("R7 clear keeps mode", rd_data, 8'h30);
    wr(8'h10);
    chk("R7 mode cleared independently", rd_data, 8'h10);
    wr(8'hC0);
    chk("R8 storage bits", rd_data, 8'hC0);
    wr(8'h40);
    chk("R8 storage pattern 2", rd_data, 8'h40);
  endtask

  task automatic t_qual();
    do_reset();
    chan_irq = 2'b11; step(); chan_irq = 2'b00;
    dma_stat0 = 8'hFB; dma_stat1 = 8'h00; #1;
    chk("R9 no status bit", {6'h0, qual_irq}, 8'h00);
    dma_stat0 = 8'h04; #1;
    chk("R9 primary only", {6'h0, qual_irq}, 8'h01);
    dma_stat1 = 8'h04; #1;
    chk("R9 both", {6'h0, qual_irq}, 8'h03);
    wr(8'h04);
    chk("R9 primary cleared", {6'h0, qual_irq}, 8'h02);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset state", rd_data, 8'h00);
    t_reset();
    t_edge_set();
    t_w1c();
    t_level();
    t_set_wins();
    t_fields();
    t_qual();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule